// File: doc/BRIEF.md
# Multi-Lane Bidirectional Shift Register

This block is a 96-stage serial shift register whose stages are shared out among 2, 3, 4 or 6 interleaved lanes, chosen at run time by a two-bit lane selector. With N lanes, lane k owns every Nth stage starting at stage k, so each lane is 96/N stages long. Every rising clock edge moves each lane forward by one of its own positions, which is N positions in the flat stage vector. The 96 stage bits are presented in parallel, so a downstream latch can capture a full row of display data.

A single direction input picks the shift direction. It also decides which side of the block serves as the lane inputs and which side drives the shifted-out bits toward the next device in a cascade. Each side-A and side-B lane port is split into a data input, a data output and an output enable, which stands in for a bidirectional pad. An active-low clear, sampled on the clock, empties all stages.

Top module: `lane_shift_reg`

## Requirements
- R1: `lane_sel` picks the lane count N: 2'b11 gives 2 lanes of 48 stages, 2'b10 gives 3 of 32, 2'b01 gives 4 of 24, 2'b00 gives 6 of 16. Lane k (0-based) owns stages k, k+N, k+2N and so on. Exactly N lanes drive an output enable.
- R2: On a rising edge with `clr_n`=1 and `shift_right`=1, stage i takes the old stage i−N for i ≥ N, and stage k takes `a_in[k]` for k < N.
- R3: On a rising edge with `clr_n`=1 and `shift_right`=0, stage i takes the old stage i+N for i < 96−N, and stage 96−N+k takes `b_in[k]` for k < N.
- R4: When side A is the output side, `a_out[k]` equals stage k. When side B is the output side, `b_out[k]` equals stage 96−N+k. Every other output data bit is 0.
- R5: With `shift_right`=1, `b_oe` has its low N bits set and `a_oe` is 0. With `shift_right`=0, `a_oe` has its low N bits set and `b_oe` is 0.
- R6: A rising edge with `clr_n`=0 sets all 96 stages to 0, whatever the shift inputs are. While `clr_n` stays low, no shift takes place.
- R7: Input bits of unused lanes (index ≥ N), and all input bits on the side currently acting as output, have no effect on the stages.
- R8: A change of `lane_sel` or `shift_right` takes effect at the next rising edge. Until that edge the stage contents are unchanged, and the edge shifts the existing contents with the new settings, without reordering them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| clr_n | input | 1 | Active-low clear of all stages, sampled on the clock |
| lane_sel | input | 2 | Lane count select (see R1) |
| shift_right | input | 1 | 1: shift toward high stages, A side in; 0: toward low stages, B side in |
| a_in | input | 6 | Side-A lane input data |
| a_out | output | 6 | Side-A lane output data |
| a_oe | output | 6 | Side-A output enable, one bit per lane |
| b_in | input | 6 | Side-B lane input data |
| b_out | output | 6 | Side-B lane output data |
| b_oe | output | 6 | Side-B output enable, one bit per lane |
| stages | output | 96 | Parallel view of every stage, bit i is stage i |

## Verification
The properties assume that all inputs are synchronous to `clk` and settle well before each rising edge. They also assume the clear is the only event that can disturb a shift between two edges, so the shift properties are disabled whenever `clr_n` is low. All four `lane_sel` codes are legal, so no input restriction is needed there. The bench changes every input one nanosecond after a rising edge and samples outputs at the same point, so each edge sees a single stable set of inputs. It deliberately drives ones on unused lanes and on the output side's inputs, which keeps it inside these assumptions while still exercising the inputs that must be ignored.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

    localparam int unsigned DFLT_STAGES = 96;
    localparam int unsigned DFLT_LANES  = 6;
    localparam int unsigned MODE_COUNT  = 4;

    // Lane-count selector codes; the code values are part of the interface.
    typedef enum logic [1:0] {
        LANES_SIX   = 2'b00,
        LANES_FOUR  = 2'b01,
        LANES_THREE = 2'b10,
        LANES_TWO   = 2'b11
    } lane_mode_e;

    // Shift control carried from the decoder to the datapath.
    typedef struct packed {
        lane_mode_e mode;
        logic       right;
    } shift_ctl_t;

    // Number of interleaved lanes for a selector code.
    function automatic int unsigned mode_lanes(input logic [1:0] code);
        case (code)
            2'b00:   return 6;
            2'b01:   return 4;
            2'b10:   return 3;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/lane_mode_dec.sv
module lane_mode_dec
    import lane_shift_pkg::*;
#(
    parameter int unsigned MAX_LANES = DFLT_LANES
) (
    input  logic [1:0]           lane_sel,
    input  logic                 shift_right,
    output shift_ctl_t           ctl,
    output logic [MAX_LANES-1:0] lane_used
);

    always_comb begin
        ctl.mode  = lane_mode_e'(lane_sel);
        ctl.right = shift_right;
        for (int unsigned k = 0; k < MAX_LANES; k++) begin
            lane_used[k] = (k < mode_lanes(lane_sel));
        end
    end

endmodule

// File: rtl/lane_shift_core.sv
module lane_shift_core
    import lane_shift_pkg::*;
#(
    parameter int unsigned STAGES    = DFLT_STAGES,
    parameter int unsigned MAX_LANES = DFLT_LANES
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  shift_ctl_t           ctl,
    input  logic [MAX_LANES-1:0] a_in,
    input  logic [MAX_LANES-1:0] b_in,
    output logic [STAGES-1:0]    stages
);

    // One next-state candidate per lane configuration and direction.
    logic [MODE_COUNT-1:0][STAGES-1:0] cand_r;
    logic [MODE_COUNT-1:0][STAGES-1:0] cand_l;

    for (genvar v = 0; v < MODE_COUNT; v++) begin : g_mode
        localparam int unsigned N   = mode_lanes(2'(v));
        localparam int unsigned TOP = STAGES - N;
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // toward higher stages: the first N stages load the A side
            if (i < N) begin : g_r_head
                assign cand_r[v][i] = a_in[i];
            end else begin : g_r_body
                assign cand_r[v][i] = stages[i-N];
            end
            // toward lower stages: the last N stages load the B side
            if (i >= TOP) begin : g_l_head
                assign cand_l[v][i] = b_in[i-TOP];
            end else begin : g_l_body
                assign cand_l[v][i] = stages[i+N];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stages <= '0;
        end else if (ctl.right) begin
            stages <= cand_r[ctl.mode];
        end else begin
            stages <= cand_l[ctl.mode];
        end
    end

endmodule

// File: rtl/lane_port_map.sv
module lane_port_map
    import lane_shift_pkg::*;
#(
    parameter int unsigned STAGES    = DFLT_STAGES,
    parameter int unsigned MAX_LANES = DFLT_LANES
) (
    input  logic [STAGES-1:0]    stages,
    input  shift_ctl_t           ctl,
    input  logic [MAX_LANES-1:0] lane_used,
    output logic [MAX_LANES-1:0] a_out,
    output logic [MAX_LANES-1:0] a_oe,
    output logic [MAX_LANES-1:0] b_out,
    output logic [MAX_LANES-1:0] b_oe
);

    // Final stage of each lane, per lane configuration.
    logic [MODE_COUNT-1:0][MAX_LANES-1:0] tail;

    for (genvar v = 0; v < MODE_COUNT; v++) begin : g_mode
        localparam int unsigned N = mode_lanes(2'(v));
        for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
            if (k < N) begin : g_live
                assign tail[v][k] = stages[STAGES-N+k];
            end else begin : g_idle
                assign tail[v][k] = 1'b0;
            end
        end
    end

    always_comb begin
        a_oe  = ctl.right ? '0 : lane_used;
        b_oe  = ctl.right ? lane_used : '0;
        a_out = a_oe & stages[MAX_LANES-1:0];
        b_out = b_oe & tail[ctl.mode];
    end

endmodule

// File: rtl/lane_shift_reg.sv
module lane_shift_reg
    import lane_shift_pkg::*;
#(
    parameter int unsigned STAGES    = DFLT_STAGES,
    parameter int unsigned MAX_LANES = DFLT_LANES
) (
    input  logic                 clk,
    input  logic                 clr_n,
    input  logic [1:0]           lane_sel,
    input  logic                 shift_right,
    input  logic [MAX_LANES-1:0] a_in,
    output logic [MAX_LANES-1:0] a_out,
    output logic [MAX_LANES-1:0] a_oe,
    input  logic [MAX_LANES-1:0] b_in,
    output logic [MAX_LANES-1:0] b_out,
    output logic [MAX_LANES-1:0] b_oe,
    output logic [STAGES-1:0]    stages
);

    shift_ctl_t           ctl;
    logic [MAX_LANES-1:0] lane_used;

    lane_mode_dec #(.MAX_LANES(MAX_LANES)) u_dec (
        .lane_sel    (lane_sel),
        .shift_right (shift_right),
        .ctl         (ctl),
        .lane_used   (lane_used)
    );

    lane_shift_core #(.STAGES(STAGES), .MAX_LANES(MAX_LANES)) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .ctl    (ctl),
        .a_in   (a_in),
        .b_in   (b_in),
        .stages (stages)
    );

    lane_port_map #(.STAGES(STAGES), .MAX_LANES(MAX_LANES)) u_map (
        .stages    (stages),
        .ctl       (ctl),
        .lane_used (lane_used),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

endmodule

// File: rtl/lane_shift_chk.sv
module lane_shift_chk
    import lane_shift_pkg::*;
#(
    parameter int unsigned STAGES    = DFLT_STAGES,
    parameter int unsigned MAX_LANES = DFLT_LANES
) (
    input logic                 clk,
    input logic                 clr_n,
    input logic [1:0]           lane_sel,
    input logic                 shift_right,
    input logic [MAX_LANES-1:0] a_in,
    input logic [MAX_LANES-1:0] a_out,
    input logic [MAX_LANES-1:0] a_oe,
    input logic [MAX_LANES-1:0] b_in,
    input logic [MAX_LANES-1:0] b_out,
    input logic [MAX_LANES-1:0] b_oe,
    input logic [STAGES-1:0]    stages
);

    // R1: the number of enabled lanes follows the selector code
    a_r1_lane_count: assert property (@(posedge clk) disable iff (!clr_n)
        $countones(a_oe | b_oe) == int'(mode_lanes(lane_sel)));

    // R2: two-lane shift toward higher stages
    a_r2_right_two_lane: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_right && lane_sel == 2'b11) |=>
            (stages[STAGES-1:2] == $past(stages[STAGES-3:0]))
            && (stages[1:0] == $past(a_in[1:0])));

    // R3: six-lane shift toward lower stages
    a_r3_left_six_lane: assert property (@(posedge clk) disable iff (!clr_n)
        (!shift_right && lane_sel == 2'b00) |=>
            (stages[STAGES-7:0] == $past(stages[STAGES-1:6]))
            && (stages[STAGES-1:STAGES-6] == $past(b_in[5:0])));

    // R4: no output data bit is active without its enable
    a_r4_out_gated: assert property (@(posedge clk) disable iff (!clr_n)
        ((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0));

    // R5: only one side drives at a time, the side chosen by direction
    a_r5_oe_one_side: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_right ? (a_oe == '0) : (b_oe == '0)));

    // R6: a clearing edge leaves every stage at zero
    logic clr_q;
    always_ff @(posedge clk) clr_q <= !clr_n;

    always @(negedge clk) begin
        if (clr_q) begin
            a_r6_clear_empty: assert (stages == '0)
                else $error("clear left a stage set");
        end
    end

endmodule

bind lane_shift_reg lane_shift_chk #(.STAGES(STAGES), .MAX_LANES(MAX_LANES)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .lane_sel    (lane_sel),
    .shift_right (shift_right),
    .a_in        (a_in),
    .a_out       (a_out),
    .a_oe        (a_oe),
    .b_in        (b_in),
    .b_out       (b_out),
    .b_oe        (b_oe),
    .stages      (stages)
);

// File: tb/lane_shift_reg_bench.sv
module lane_shift_reg_bench;

    localparam int ST = 96;
    localparam int ML = 6;

    logic          clk = 1'b0;
    logic          clr_n;
    logic [1:0]    lane_sel;
    logic          shift_right;
    logic [ML-1:0] a_in, b_in;
    logic [ML-1:0] a_out, a_oe, b_out, b_oe;
    logic [ST-1:0] stages;

    always #10 clk = ~clk;

    lane_shift_reg u_lane_shift_reg (
        .clk (clk), .clr_n (clr_n), .lane_sel (lane_sel), .shift_right (shift_right),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
        .stages (stages)
    );

    int checks = 0;
    int fails  = 0;
    logic [ST-1:0] model;

    typedef struct packed {
        logic [1:0] sel;
        logic       right;
        logic [5:0] pat;
        logic [7:0] steps;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b11, 1'b1, 6'b000011, 8'd50},
        '{2'b10, 1'b1, 6'b000101, 8'd33},
        '{2'b01, 1'b1, 6'b001010, 8'd25},
        '{2'b00, 1'b1, 6'b101101, 8'd17},
        '{2'b11, 1'b0, 6'b000010, 8'd48},
        '{2'b10, 1'b0, 6'b000110, 8'd32},
        '{2'b01, 1'b0, 6'b001001, 8'd24},
        '{2'b00, 1'b0, 6'b110011, 8'd16}
    };

    function automatic int lanes_for(logic [1:0] sel);
        case (sel)
            2'b00:   return 6;
            2'b01:   return 4;
            2'b10:   return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [ML-1:0] mask_for(int n);
        logic [ML-1:0] m;
        for (int k = 0; k < ML; k++) m[k] = (k < n);
        return m;
    endfunction

    function automatic logic [ST-1:0] ref_step(logic [ST-1:0] s, int n, logic right,
                                               logic [ML-1:0] ai, logic [ML-1:0] bi);
        logic [ST-1:0] r;
        for (int i = 0; i < ST; i++) begin
            if (right) begin
                if (i < n) r[i] = ai[i];
                else       r[i] = s[i-n];
            end else begin
                if (i >= ST-n) r[i] = bi[i-(ST-n)];
                else           r[i] = s[i+n];
            end
        end
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [ST-1:0] act, logic [ST-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_ports(string tag);
        int            n;
        logic [ML-1:0] m, ea, eb;
        n = lanes_for(lane_sel);
        m = mask_for(n);
        ea = '0;
        eb = '0;
        for (int k = 0; k < n; k++) begin
            ea[k] = model[k];
            eb[k] = model[ST-n+k];
        end
        if (shift_right) begin
            chk("R4", "a_out", ST'(a_out), '0);
            chk("R4", "b_out", ST'(b_out), ST'(eb));
            chk("R5", "a_oe", ST'(a_oe), '0);
            chk("R5", "b_oe", ST'(b_oe), ST'(m));
        end else begin
            chk("R4", "a_out", ST'(a_out), ST'(ea));
            chk("R4", "b_out", ST'(b_out), '0);
            chk("R5", "a_oe", ST'(a_oe), ST'(m));
            chk("R5", "b_oe", ST'(b_oe), '0);
        end
        chk(tag, "stages", stages, model);
    endtask

    task automatic step(logic [ML-1:0] ai, logic [ML-1:0] bi);
        a_in = ai;
        b_in = bi;
        if (!clr_n) model = '0;
        else model = ref_step(model, lanes_for(lane_sel), shift_right, ai, bi);
        @(posedge clk);
        #1;
    endtask

    task automatic do_clear();
        clr_n = 1'b0;
        step('1, '1);
        clr_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        clr_n = 1'b0;
        lane_sel = 2'b11;
        shift_right = 1'b1;
        a_in = '0;
        b_in = '0;
        model = '0;

        // reset state
        step('1, '1);
        chk("R6", "stages after clear", stages, '0);
        chk("R6", "a_out after clear", ST'(a_out), '0);
        chk("R6", "b_out after clear", ST'(b_out), '0);
        clr_n = 1'b1;

        // table walk: R2 / R3 on every edge, R7 via ones on ignored inputs
        foreach (VECS[r]) begin
            int            n;
            logic [ML-1:0] m, drv;
            do_clear();
            lane_sel = VECS[r].sel;
            shift_right = VECS[r].right;
            n = lanes_for(VECS[r].sel);
            m = mask_for(n);
            for (int j = 0; j <= int'(VECS[r].steps); j++) begin
                if (j == 0)      drv = VECS[r].pat;
                else if (j == 2) drv = ~VECS[r].pat;
                else             drv = '0;
                drv = drv | ~m;
                if (shift_right) step(drv, '1);
                else             step('1, drv);
                chk_ports(shift_right ? "R2" : "R3");
            end
            chk("R1", "enabled lane count", ST'($countones(a_oe | b_oe)), ST'(n));
        end

        // clear wins over shifting and holds the register empty
        do_clear();
        lane_sel = 2'b00;
        shift_right = 1'b1;
        for (int j = 0; j < 5; j++) step('1, '1);
        chk("R2", "stages before clear", stages, model);
        clr_n = 1'b0;
        for (int j = 0; j < 3; j++) begin
            step('1, '1);
            chk("R6", "stages while clear held", stages, '0);
        end
        clr_n = 1'b1;

        // unused lanes and output-side inputs ignored
        lane_sel = 2'b11;
        shift_right = 1'b1;
        step(6'b111100, '1);
        chk("R7", "two-lane right, unused inputs high", stages, '0);
        chk("R7", "a_out stays idle", ST'(a_out), '0);
        lane_sel = 2'b01;
        shift_right = 1'b0;
        step('1, 6'b110000);
        chk("R7", "four-lane left, unused inputs high", stages, '0);

        // mode and direction change apply at the next edge only
        do_clear();
        lane_sel = 2'b11;
        shift_right = 1'b1;
        for (int j = 0; j < 3; j++) step(6'b000001, '0);
        lane_sel = 2'b00;
        #5;
        chk("R8", "no change before edge", stages, model);
        step('0, '0);
        chk_ports("R8");
        shift_right = 1'b0;
        #5;
        chk("R8", "direction change before edge", stages, model);
        step('0, 6'b100001);
        chk_ports("R8");
        lane_sel = 2'b10;
        step('0, 6'b000010);
        chk_ports("R8");

        finish_run();
    end

endmodule